// File: doc/BRIEF.md
# Byte ALU with Status Flag Update

This block is the execution arithmetic of a small microcontroller-style core. In one cycle it takes a destination operand, a source operand or immediate, a 4-bit operation code and the current 8-bit status byte. From these it produces an 8-bit result, a flag that says whether the result should be written back, and the next status byte. The result, the write enable and the next status byte are combinational. A registered copy of the status byte is captured on a rising clock edge whenever the operation is marked valid.

Each operation changes only its own fixed set of status bits. Every bit outside that set passes straight from the input status byte to the output. The operations are add with carry, compare with carry, compare against an immediate, subtract an immediate with carry, increment, two's-complement negate, logical shift right, rotate right through carry and nibble swap.

Status byte layout, from bit 0 upward: C carry (0), Z zero (1), N negative (2), V signed overflow (3), S sign = N xor V (4), H half carry (5), T (6), I (7).

Top module: `alu8_status_unit`

## Requirements
- R1: Status bits 7 (I) and 6 (T) of `flags_next` always equal those of `flags_in`. Bit positions are C=0, Z=1, N=2, V=3, S=4, H=5.
- R2: Add with carry (code 0) gives d+s+C mod 256 and writes it back. C is the carry out of bit 7 and H the carry out of bit 3. V is set when both operands have the same sign and the result sign differs. It updates H, S, V, N, Z and C.
- R3: Compare with carry (code 1) and subtract immediate with carry (code 3) compute d-s-C. C is the borrow out of bit 7 and H the borrow out of bit 3. V is set on signed overflow. Z is set only if the result is zero and Z was already set, so these two codes can clear Z but never set it. They update H, S, V, N, Z and C.
- R4: Compare immediate (code 2) computes d-s with no carry in and takes Z from the result alone. Its other flags follow R3.
- R5: Codes 1 and 2 drive the difference on `result` with `result_we` low. Code 3 drives the difference with `result_we` high.
- R6: Increment (code 4) gives d+1 mod 256 and writes it back. V is set only when the result is 0x80. It updates S, V, N and Z and leaves C and H unchanged.
- R7: Negate (code 5) gives 0-d mod 256 and writes it back. C is set when the result is nonzero and V when the result is 0x80. It updates S, V, N, Z and C and leaves H unchanged.
- R8: Logical shift right (code 6) gives d>>1 and writes it back. C takes d bit 0, N is cleared and V = N xor C. It updates S, V, N, Z and C.
- R9: Rotate right (code 7) gives the input C in bit 7 and d>>1 below it, and writes it back. C takes d bit 0, N takes the result's bit 7 and V = N xor C. It updates S, V, N, Z and C.
- R10: Nibble swap (code 8) exchanges the upper and lower nibbles of d, writes the result back and leaves all status bits unchanged.
- R11: Every code that updates S sets it to N xor V of the new flags.
- R12: `flags_q` resets to 0. It takes `flags_next` on a rising edge when `op_valid` is high and holds its value otherwise.
- R13: Codes 9 to 15 give result 0 and `result_we` low, with `flags_next` equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation valid; enables the status capture |
| op_sel | input | 4 | Operation code (0..8 defined) |
| opnd_d | input | 8 | Destination operand |
| opnd_s | input | 8 | Source operand or immediate |
| flags_in | input | 8 | Current status byte |
| result | output | 8 | Operation result |
| result_we | output | 1 | Result write-back enable |
| flags_next | output | 8 | Updated status byte (combinational) |
| flags_q | output | 8 | Registered status byte |

## Verification
The checker watches several rules on every cycle. I and T always pass through unchanged. Compares never write back. Compare with carry never raises Z. Increment keeps C and H, and nibble swap keeps every flag. The shift codes obey V = N xor C and rotate feeds the old carry into bit 7. S equals N xor V for every code that updates it. Undefined codes pass the flags through, and the register captures or holds according to `op_valid`. The exact arithmetic values can only be shown by the bench's scenarios, which compare against a reference model on directed and random operands. That covers the half-carry and borrow behaviour at nibble boundaries, the overflow cases at 0x7F/0x80 and the carry-chain compare sequences.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADC  = 4'd0,
      OP_CPC  = 4'd1,
      OP_CPI  = 4'd2,
      OP_SBCI = 4'd3,
      OP_INC  = 4'd4,
      OP_NEG  = 4'd5,
      OP_LSR  = 4'd6,
      OP_ROR  = 4'd7,
      OP_SWAP = 4'd8
   } alu_op_e;

   localparam int FLAG_W = 8;
   localparam int F_C = 0;
   localparam int F_Z = 1;
   localparam int F_N = 2;
   localparam int F_V = 3;
   localparam int F_S = 4;
   localparam int F_H = 5;
   localparam int F_T = 6;
   localparam int F_I = 7;

   localparam logic [FLAG_W-1:0] FM_HSVNZC = 8'b0011_1111;
   localparam logic [FLAG_W-1:0] FM_SVNZC  = 8'b0001_1111;
   localparam logic [FLAG_W-1:0] FM_SVNZ   = 8'b0001_1110;
   localparam logic [FLAG_W-1:0] FM_NONE   = 8'b0000_0000;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
   import alu8_pkg::*;
#(
   parameter int DW = 8
) (
   input  alu_op_e           op,
   input  logic [DW-1:0]     a,
   input  logic [DW-1:0]     b,
   input  logic              cin,
   input  logic              zin,
   output logic              hit,
   output logic              we,
   output logic [DW-1:0]     res,
   output logic [FLAG_W-1:0] fval,
   output logic [FLAG_W-1:0] fmask
);
   localparam int MSB = DW - 1;
   localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

   logic          cuse;
   logic [DW:0]   add_w;
   logic [DW:0]   sub_w;
   logic [4:0]    add_n;
   logic [4:0]    sub_n;
   logic          c_f, h_f, v_f, z_f;

   assign cuse  = (op == OP_CPI) ? 1'b0 : cin;
   assign add_w = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cuse};
   assign sub_w = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cuse};
   assign add_n = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cuse};
   assign sub_n = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'd0, cuse};

   always_comb begin
      hit   = 1'b1;
      we    = 1'b1;
      res   = '0;
      c_f   = 1'b0;
      h_f   = 1'b0;
      v_f   = 1'b0;
      fmask = FM_NONE;
      case (op)
         OP_ADC: begin
            res   = add_w[MSB:0];
            c_f   = add_w[DW];
            h_f   = add_n[4];
            v_f   = (a[MSB] == b[MSB]) && (add_w[MSB] != a[MSB]);
            fmask = FM_HSVNZC;
         end
         OP_CPC, OP_CPI, OP_SBCI: begin
            res   = sub_w[MSB:0];
            c_f   = sub_w[DW];
            h_f   = sub_n[4];
            v_f   = (a[MSB] != b[MSB]) && (sub_w[MSB] != a[MSB]);
            we    = (op == OP_SBCI);
            fmask = FM_HSVNZC;
         end
         OP_INC: begin
            res   = a + {{(DW-1){1'b0}}, 1'b1};
            v_f   = (res == SMIN);
            fmask = FM_SVNZ;
         end
         OP_NEG: begin
            res   = '0 - a;
            c_f   = (res != '0);
            v_f   = (res == SMIN);
            fmask = FM_SVNZC;
         end
         default: begin
            hit = 1'b0;
            we  = 1'b0;
         end
      endcase
   end

   // zero flag: carry-chained subtracts can only keep or clear it
   always_comb begin
      z_f = (res == '0);
      if (op == OP_CPC || op == OP_SBCI) begin
         z_f = z_f & zin;
      end
   end

   always_comb begin
      fval      = '0;
      fval[F_C] = c_f;
      fval[F_Z] = z_f;
      fval[F_N] = res[MSB];
      fval[F_V] = v_f;
      fval[F_S] = res[MSB] ^ v_f;
      fval[F_H] = h_f;
   end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
   import alu8_pkg::*;
#(
   parameter int DW = 8
) (
   input  alu_op_e           op,
   input  logic [DW-1:0]     a,
   input  logic              cin,
   output logic              hit,
   output logic              we,
   output logic [DW-1:0]     res,
   output logic [FLAG_W-1:0] fval,
   output logic [FLAG_W-1:0] fmask
);
   localparam int MSB  = DW - 1;
   localparam int HALF = DW / 2;

   logic fill;
   logic n_f, v_f;

   assign fill = (op == OP_ROR) ? cin : 1'b0;

   always_comb begin
      hit   = 1'b1;
      we    = 1'b1;
      res   = '0;
      fmask = FM_NONE;
      case (op)
         OP_LSR, OP_ROR: begin
            res   = {fill, a[MSB:1]};
            fmask = FM_SVNZC;
         end
         OP_SWAP: begin
            res = {a[HALF-1:0], a[MSB:HALF]};
         end
         default: begin
            hit = 1'b0;
            we  = 1'b0;
         end
      endcase
   end

   assign n_f = res[MSB];
   assign v_f = n_f ^ a[0];

   always_comb begin
      fval      = '0;
      fval[F_C] = a[0];
      fval[F_Z] = (res == '0);
      fval[F_N] = n_f;
      fval[F_V] = v_f;
      fval[F_S] = n_f ^ v_f;
   end

endmodule

// File: rtl/alu8_merge.sv
module alu8_merge
   import alu8_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [FLAG_W-1:0] flags_in,
   input  logic              ar_hit,
   input  logic              ar_we,
   input  logic [DW-1:0]     ar_res,
   input  logic [FLAG_W-1:0] ar_val,
   input  logic [FLAG_W-1:0] ar_mask,
   input  logic              sh_hit,
   input  logic              sh_we,
   input  logic [DW-1:0]     sh_res,
   input  logic [FLAG_W-1:0] sh_val,
   input  logic [FLAG_W-1:0] sh_mask,
   output logic [DW-1:0]     result,
   output logic              result_we,
   output logic [FLAG_W-1:0] flags_next
);
   localparam logic [FLAG_W-1:0] KEEP_IT = 8'b1100_0000;

   logic [FLAG_W-1:0] sel_val;
   logic [FLAG_W-1:0] sel_mask;

   always_comb begin
      if (ar_hit) begin
         result    = ar_res;
         result_we = ar_we;
         sel_val   = ar_val;
         sel_mask  = ar_mask;
      end else if (sh_hit) begin
         result    = sh_res;
         result_we = sh_we;
         sel_val   = sh_val;
         sel_mask  = sh_mask;
      end else begin
         result    = '0;
         result_we = 1'b0;
         sel_val   = '0;
         sel_mask  = FM_NONE;
      end
   end

   assign flags_next = ((sel_mask & ~KEEP_IT) & sel_val)
                     | (~(sel_mask & ~KEEP_IT) & flags_in);

endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
   import alu8_pkg::*;
#(
   parameter int              DW             = 8,
   parameter bit              REGISTER_FLAGS = 1'b1,
   parameter logic [7:0]      FLAGS_RESET    = 8'h00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [3:0]    op_sel,
   input  logic [DW-1:0] opnd_d,
   input  logic [DW-1:0] opnd_s,
   input  logic [7:0]    flags_in,
   output logic [DW-1:0] result,
   output logic          result_we,
   output logic [7:0]    flags_next,
   output logic [7:0]    flags_q
);
   if (DW < 8 || (DW % 2) != 0) begin : g_bad_width
      $error("alu8_status_unit: DW must be even and at least 8");
   end

   alu_op_e           op_e;
   logic              ar_hit, ar_we, sh_hit, sh_we;
   logic [DW-1:0]     ar_res, sh_res;
   logic [FLAG_W-1:0] ar_val, ar_mask, sh_val, sh_mask;

   assign op_e = alu_op_e'(op_sel);

   alu8_arith #(.DW(DW)) u_arith (
      .op    (op_e),
      .a     (opnd_d),
      .b     (opnd_s),
      .cin   (flags_in[F_C]),
      .zin   (flags_in[F_Z]),
      .hit   (ar_hit),
      .we    (ar_we),
      .res   (ar_res),
      .fval  (ar_val),
      .fmask (ar_mask)
   );

   alu8_shift #(.DW(DW)) u_shift (
      .op    (op_e),
      .a     (opnd_d),
      .cin   (flags_in[F_C]),
      .hit   (sh_hit),
      .we    (sh_we),
      .res   (sh_res),
      .fval  (sh_val),
      .fmask (sh_mask)
   );

   alu8_merge #(.DW(DW)) u_merge (
      .flags_in   (flags_in),
      .ar_hit     (ar_hit),
      .ar_we      (ar_we),
      .ar_res     (ar_res),
      .ar_val     (ar_val),
      .ar_mask    (ar_mask),
      .sh_hit     (sh_hit),
      .sh_we      (sh_we),
      .sh_res     (sh_res),
      .sh_val     (sh_val),
      .sh_mask    (sh_mask),
      .result     (result),
      .result_we  (result_we),
      .flags_next (flags_next)
   );

   if (REGISTER_FLAGS) begin : g_flag_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q <= FLAGS_RESET;
         end else if (op_valid) begin
            flags_q <= flags_next;
         end
      end
   end else begin : g_flag_pass
      assign flags_q = flags_next;
   end

endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
   import alu8_pkg::*;
#(
   parameter int DW  = 8,
   parameter bit REG = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          op_valid,
   input logic [3:0]    op_sel,
   input logic [7:0]    flags_in,
   input logic [DW-1:0] result,
   input logic          result_we,
   input logic [7:0]    flags_next,
   input logic [7:0]    flags_q
);
   logic is_shift, upd_s;
   assign is_shift = (op_sel == OP_LSR) || (op_sel == OP_ROR);
   assign upd_s    = (op_sel <= 4'd7);

   a_r1_it_kept: assert property (@(posedge clk) disable iff (!rst_n)
      flags_next[7:6] == flags_in[7:6]);

   a_r3_cpc_z_never_set: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_CPC && !flags_in[F_Z]) |-> !flags_next[F_Z]);

   a_r5_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_CPC || op_sel == OP_CPI) |-> !result_we);

   a_r6_inc_keeps_ch: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_INC) |-> (flags_next[F_C] == flags_in[F_C]
                              && flags_next[F_H] == flags_in[F_H]));

   a_r8_shift_v: assert property (@(posedge clk) disable iff (!rst_n)
      is_shift |-> (flags_next[F_V] == (flags_next[F_N] ^ flags_next[F_C])));

   a_r9_ror_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_ROR) |-> (result[DW-1] == flags_in[F_C]));

   a_r10_swap_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_SWAP) |-> (flags_next == flags_in && result_we));

   a_r11_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
      upd_s |-> (flags_next[F_S] == (flags_next[F_N] ^ flags_next[F_V])));

   a_r13_undef_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > 4'd8) |-> (flags_next == flags_in && !result_we));

   if (REG) begin : g_reg_chk
      a_r12_capture: assert property (@(posedge clk) disable iff (!rst_n)
         op_valid |=> (flags_q == $past(flags_next)));
      a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !op_valid |=> $stable(flags_q));
   end

endmodule

bind alu8_status_unit alu8_status_chk #(.DW(DW), .REG(REGISTER_FLAGS)) u_status_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_sel     (op_sel),
   .flags_in   (flags_in),
   .result     (result),
   .result_we  (result_we),
   .flags_next (flags_next),
   .flags_q    (flags_q)
);

// File: tb/test_alu8_status_unit.sv
`timescale 1ns/1ps
module test_alu8_status_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] op_sel = 4'd0;
   logic [7:0] opnd_d = 8'd0, opnd_s = 8'd0, flags_in = 8'd0;
   logic [7:0] result, flags_next, flags_q;
   logic       result_we;

   int checks = 0, fails = 0;
   logic [7:0] exp_q = 8'h00;

   always #10 clk = ~clk;

   alu8_status_unit i_alu8_status_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .opnd_d(opnd_d), .opnd_s(opnd_s), .flags_in(flags_in),
      .result(result), .result_we(result_we),
      .flags_next(flags_next), .flags_q(flags_q));

   function automatic string req_of(int op);
      case (op)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R3";
         4: return "R6";
         5: return "R7";
         6: return "R8";
         7: return "R9";
         8: return "R10";
         default: return "R13";
      endcase
   endfunction

   // reference: {we, result, flags}
   function automatic logic [16:0] model(int op, int a, int b, logic [7:0] s);
      int r = 0, d, cc;
      bit c = s[0], h = s[5], v = s[3], n = s[2], z = s[1], sg = s[4];
      bit we = 0, touch_s = 0;
      int ci = s[0];
      logic [7:0] f = s;
      case (op)
         0: begin
            d = a + b + ci; r = d % 256; c = (d > 255);
            h = ((a % 16) + (b % 16) + ci) > 15;
            v = ((a ^ r) & (b ^ r) & 128) != 0;
            z = (r == 0); we = 1; touch_s = 1;
         end
         1, 2, 3: begin
            cc = (op == 2) ? 0 : ci;
            d = a - b - cc; r = (d + 512) % 256; c = (d < 0);
            h = ((a % 16) - (b % 16) - cc) < 0;
            v = ((a ^ b) & (a ^ r) & 128) != 0;
            z = (r == 0) && (op == 2 || s[1]);
            we = (op == 3); touch_s = 1;
         end
         4: begin
            r = (a + 1) % 256; v = (a == 127); z = (r == 0); we = 1; touch_s = 1;
         end
         5: begin
            r = (256 - a) % 256; c = (a != 0); v = (a == 128);
            z = (r == 0); we = 1; touch_s = 1;
         end
         6, 7: begin
            r = a / 2 + ((op == 7) ? ci * 128 : 0); c = (a % 2) != 0;
            z = (r == 0); we = 1; touch_s = 1;
         end
         8: begin
            r = (a % 16) * 16 + a / 16; we = 1;
         end
         default: r = 0;
      endcase
      if (touch_s) begin
         n  = (r >= 128);
         if (op == 6 || op == 7) v = n ^ c;
         sg = n ^ v;
         f[0] = c; f[1] = z; f[2] = n; f[3] = v; f[4] = sg; f[5] = h;
      end
      return {we, 8'(r), f};
   endfunction

   task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
      end
   endtask

   task automatic step(int op, int a, int b, logic [7:0] s, bit vld);
      logic [16:0] m;
      @(negedge clk);
      check8("R12", "flags_q", flags_q, exp_q);
      op_sel = 4'(op); opnd_d = 8'(a); opnd_s = 8'(b); flags_in = s; op_valid = vld;
      #3;
      m = model(op, a, b, s);
      check8(req_of(op), "result", result, m[15:8]);
      check8(req_of(op), "result_we", {7'd0, result_we}, {7'd0, m[16]});
      check8(req_of(op), "flags_next", flags_next, m[7:0]);
      check8("R1", "I/T bits", {6'd0, flags_next[7:6]}, {6'd0, s[7:6]});
      if (op <= 7)
         check8("R11", "S vs N^V", {7'd0, flags_next[4]},
                {7'd0, flags_next[2] ^ flags_next[3]});
      if (vld) exp_q = m[7:0];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 check8("R12", "reset flags_q", flags_q, 8'h00);
      @(negedge clk) rst_n = 1'b1;
      // R2 directed
      step(0, 10, 20, 8'h01, 1);
      check8("R2", "adc 10+20+1", result, 8'd31);
      step(0, 10, 245, 8'h01, 1);
      check8("R2", "adc flags H Z C", flags_next, 8'h23);
      // R3 compare with carry, Z cannot be set
      step(1, 0, 0, 8'h81, 1);
      check8("R3", "cpc 0-0-1", flags_next, 8'hB5);
      step(1, 5, 5, 8'h00, 1);
      check8("R3", "cpc equal keeps Z clear", {7'd0, flags_next[1]}, 8'd0);
      step(1, 5, 5, 8'h02, 1);
      check8("R3", "cpc equal with Z set", {7'd0, flags_next[1]}, 8'd1);
      // R4 compare immediate
      step(2, 8, 9, 8'h00, 1);
      check8("R4", "cpi 8-9", flags_next, 8'h35);
      step(2, 9, 9, 8'h00, 1);
      check8("R4", "cpi equal sets Z", {7'd0, flags_next[1]}, 8'd1);
      // R5 subtract immediate writes
      step(3, 3, 3, 8'h81, 1);
      check8("R5", "sbci flags", flags_next, 8'hB5);
      check8("R5", "sbci writes", {7'd0, result_we}, 8'd1);
      // R6 increment
      step(4, 8'h7F, 0, 8'h00, 1);
      check8("R6", "inc 7F flags", flags_next, 8'h0C);
      step(4, 8'hFF, 0, 8'h21, 1);
      check8("R6", "inc FF keeps C H", flags_next, 8'h23);
      // R7 negate
      step(5, 8'h56, 0, 8'h00, 1);
      check8("R7", "neg 56", result, 8'hAA);
      step(5, 8'h80, 0, 8'h00, 1);
      step(5, 0, 0, 8'h20, 1);
      // R8 / R9 shifts
      step(6, 8'h45, 0, 8'h00, 1);
      check8("R8", "lsr 45 flags", flags_next, 8'h19);
      step(7, 8'h11, 0, 8'h00, 1);
      check8("R9", "ror 11 flags", flags_next, 8'h19);
      step(7, 8'h00, 0, 8'h01, 1);
      check8("R9", "ror carry into msb", result, 8'h80);
      // R10 swap
      step(8, 8'hA5, 0, 8'h6B, 1);
      check8("R10", "swap A5", result, 8'h5A);
      // R12 hold when not valid, R13 undefined codes
      step(0, 200, 100, 8'h00, 0);
      step(9, 1, 2, 8'hC3, 1);
      step(15, 77, 3, 8'h3C, 0);
      // random sweep across all codes
      for (int i = 0; i < 600; i++) begin
         step(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)), 8'($urandom), bit'($urandom_range(0, 1)));
      end
      step(8, 0, 0, 8'h00, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule